// File: doc/BRIEF.md
# Ping-Pong Recirculating Vector Buffer

This block holds the vector operand of a matrix-by-vector product in two small FIFOs. The FIFOs take turns. One of them replays its stored vector to the multiply datapath once for every matrix row. Meanwhile the other accepts the next vector from the input stream, so new vector data keeps arriving while the products are formed. On the replaying FIFO, every element that is read out is written straight back into the same FIFO in the same cycle. The vector therefore circulates without being reloaded.

After reset, the first FIFO is loaded with a complete vector before any output appears. From then on, the replaying FIFO stops writing elements back during its final pass. It drains to empty during that pass and afterwards becomes the loading FIFO. The roles change only when the loading FIFO holds a full vector. Until it does, the output side idles and reports that it is waiting. The pass count is taken from a configuration input at the moment a vector starts replaying. Each output element carries an end-of-row mark and a final-pass mark.

Top module: `pp_vec_recirc`

## Requirements
- R1: While reset is held and in the cycle after it is released, `out_valid` is 0, `in_ready` is 1, `stat_waiting` is 1 and `stat_active_sel` is 0 (the first FIFO).
- R2: After reset, `out_valid` stays 0 until VEC_LEN elements have been accepted. It rises within a few cycles of the last of them being accepted.
- R3: A vector with elements e0..e(VEC_LEN-1), in acceptance order, is presented as that same sequence repeated once per pass. Vectors come out in the order they were accepted.
- R4: `out_last_row` is 1 exactly on the element at position VEC_LEN-1 of every pass.
- R5: `out_last_vec` is 1 on every element of the final pass of a vector and 0 on the elements of all earlier passes.
- R6: While one vector is being replayed, the next vector is accepted into the other FIFO without waiting for the replay to finish.
- R7: Once the loading FIFO holds VEC_LEN elements, `in_ready` is 0. Words offered while it is 0 are not taken, and a stored vector is never overwritten.
- R8: When a replay ends and the loading FIFO is not yet full, `out_valid` is 0 and `stat_waiting` is 1, and the roles do not change until the loading FIFO is full.
- R9: `stat_active_sel` toggles on every role change and at no other time.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` and the marks stay unchanged.
- R11: The number of passes is the value of `cfg_rows` sampled when a vector starts replaying. Later changes do not affect that vector, and a sampled value of 0 means one pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word offered |
| in_data | input | DATA_W | Vector element in |
| in_ready | output | 1 | Loading FIFO can take a word |
| cfg_rows | input | ROW_W | Passes per vector, sampled when a vector starts replaying |
| out_ready | input | 1 | Multiply datapath takes the element |
| out_valid | output | 1 | Element available |
| out_data | output | DATA_W | Vector element out |
| out_last_row | output | 1 | Last element of a pass |
| out_last_vec | output | 1 | Element belongs to the final pass |
| stat_waiting | output | 1 | No vector is being replayed |
| stat_active_sel | output | 1 | Index of the replaying FIFO |

## Verification
The hardest condition to reach is a vector that is fully loaded and blocked at `in_ready` while a different vector is still replaying. This is the only point where an overwrite could occur. The stimulus reaches it by pushing the next vector early, then one more vector, while a long replay is in progress. A back-pressure stall is placed inside the same replay. The later vectors must still come out intact and in order, with a pass count of 0 read as one pass.

// File: rtl/ppv_pkg.sv
`timescale 1ns/1ps
package ppv_pkg;

    typedef enum logic [1:0] {
        PPV_LOAD = 2'd0,
        PPV_RUN  = 2'd1,
        PPV_WAIT = 2'd2
    } ppv_phase_e;

    typedef struct packed {
        logic end_row;
        logic end_vec;
    } ppv_mark_t;

    function automatic int unsigned eff_passes(input int unsigned req);
        return (req == 0) ? 1 : req;
    endfunction

endpackage

// File: rtl/ppv_fifo.sv
`timescale 1ns/1ps
module ppv_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  level
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign head = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |-> (level < CNT_W'(DEPTH)));

    a_r3_no_underflow: assert property (@(posedge clk) disable iff (rst)
        pop |-> (level != '0));

endmodule

// File: rtl/ppv_ctrl.sv
`timescale 1ns/1ps
module ppv_ctrl
    import ppv_pkg::*;
#(
    parameter int VEC_LEN = 4,
    parameter int ROW_W   = 8,
    parameter int CNT_W   = 3,
    localparam int IDX_W  = (VEC_LEN > 1) ? $clog2(VEC_LEN) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0][CNT_W-1:0] level_q,
    input  logic [ROW_W-1:0]      cfg_rows,
    input  logic                  out_ready,
    output logic                  sel_q,
    output logic                  fill_idx,
    output logic                  in_ready,
    output logic                  out_valid,
    output logic                  fire,
    output logic                  recirc,
    output logic                  final_pass,
    output ppv_mark_t             mark,
    output ppv_phase_e            phase_q
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(VEC_LEN);

    logic [IDX_W-1:0] elem_q;
    logic [ROW_W-1:0] pass_q;
    logic [ROW_W-1:0] rows_q;
    logic [ROW_W-1:0] rows_eff;
    logic [CNT_W-1:0] act_lvl;
    logic [CNT_W-1:0] fill_lvl;

    assign rows_eff   = ROW_W'(eff_passes(32'(cfg_rows)));
    assign fill_idx   = (phase_q == PPV_LOAD) ? sel_q : ~sel_q;
    assign act_lvl    = level_q[sel_q];
    assign fill_lvl   = level_q[fill_idx];
    assign in_ready   = (fill_lvl != FULL);
    assign out_valid  = (phase_q == PPV_RUN);
    assign fire       = out_valid && out_ready;
    assign final_pass = (pass_q == rows_q - 1'b1);
    assign recirc     = fire && !final_pass;

    always_comb begin
        mark.end_row = (elem_q == IDX_W'(VEC_LEN - 1));
        mark.end_vec = final_pass;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PPV_LOAD;
            sel_q   <= 1'b0;
            elem_q  <= '0;
            pass_q  <= '0;
            rows_q  <= ROW_W'(1);
        end else begin
            case (phase_q)
                PPV_LOAD: begin
                    if (act_lvl == FULL) begin
                        phase_q <= PPV_RUN;
                        rows_q  <= rows_eff;
                        elem_q  <= '0;
                        pass_q  <= '0;
                    end
                end
                PPV_RUN: begin
                    if (fire) begin
                        if (mark.end_row) begin
                            elem_q <= '0;
                            if (final_pass) begin
                                pass_q  <= '0;
                                phase_q <= PPV_WAIT;
                            end else begin
                                pass_q <= pass_q + 1'b1;
                            end
                        end else begin
                            elem_q <= elem_q + 1'b1;
                        end
                    end
                end
                PPV_WAIT: begin
                    if (fill_lvl == FULL) begin
                        sel_q   <= ~sel_q;
                        phase_q <= PPV_RUN;
                        rows_q  <= rows_eff;
                    end
                end
                default: phase_q <= PPV_LOAD;
            endcase
        end
    end

    a_r9_swap_only_from_wait: assert property (@(posedge clk) disable iff (rst)
        !$stable(sel_q) |-> ($past(phase_q) == PPV_WAIT));

    a_r8_hold_until_full: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PPV_WAIT && fill_lvl != FULL) |=> (phase_q == PPV_WAIT && $stable(sel_q)));

endmodule

// File: rtl/pp_vec_recirc.sv
`timescale 1ns/1ps
module pp_vec_recirc
    import ppv_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int VEC_LEN = 4,
    parameter int ROW_W   = 8,
    localparam int CNT_W  = $clog2(VEC_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    input  logic [ROW_W-1:0]  cfg_rows,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last_row,
    output logic              out_last_vec,
    output logic              stat_waiting,
    output logic              stat_active_sel
);

    logic [1:0][CNT_W-1:0]  level_q;
    logic [1:0][DATA_W-1:0] head_q;
    logic [1:0]             push_v;
    logic [1:0]             pop_v;
    logic [1:0][DATA_W-1:0] push_d;

    logic       sel_q;
    logic       fill_idx;
    logic       fire;
    logic       recirc;
    logic       final_pass;
    logic       accept;
    ppv_mark_t  mark;
    ppv_phase_e phase_q;

    ppv_ctrl #(
        .VEC_LEN (VEC_LEN),
        .ROW_W   (ROW_W),
        .CNT_W   (CNT_W)
    ) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .level_q    (level_q),
        .cfg_rows   (cfg_rows),
        .out_ready  (out_ready),
        .sel_q      (sel_q),
        .fill_idx   (fill_idx),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .fire       (fire),
        .recirc     (recirc),
        .final_pass (final_pass),
        .mark       (mark),
        .phase_q    (phase_q)
    );

    assign accept = in_valid && in_ready;

    for (genvar g = 0; g < 2; g++) begin : g_bank
        logic is_act;
        assign is_act    = (sel_q == 1'(g));
        assign push_v[g] = (accept && fill_idx == 1'(g)) || (recirc && is_act);
        assign push_d[g] = (recirc && is_act) ? head_q[g] : in_data;
        assign pop_v[g]  = fire && is_act;

        ppv_fifo #(
            .DATA_W (DATA_W),
            .DEPTH  (VEC_LEN)
        ) fifo_i (
            .clk       (clk),
            .rst       (rst),
            .push      (push_v[g]),
            .push_data (push_d[g]),
            .pop       (pop_v[g]),
            .head      (head_q[g]),
            .level     (level_q[g])
        );
    end

    assign out_data        = head_q[sel_q];
    assign out_last_row    = out_valid && mark.end_row;
    assign out_last_vec    = out_valid && mark.end_vec;
    assign stat_waiting    = (phase_q != PPV_RUN);
    assign stat_active_sel = sel_q;

    a_r3_level_held: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !final_pass) |-> (level_q[sel_q] == CNT_W'(VEC_LEN)));

    a_r10_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last_row)));

    a_r7_refuse_when_full: assert property (@(posedge clk) disable iff (rst)
        (level_q[fill_idx] == CNT_W'(VEC_LEN)) |-> !push_v[fill_idx] || recirc);

endmodule

// File: tb/pp_vec_recirc_tb_top.sv
`timescale 1ns/1ps
module pp_vec_recirc_tb_top;

    localparam int DW = 32;
    localparam int N  = 4;
    localparam int RW = 8;
    localparam int NT = 4;
    localparam int MAXQ = 1024;

    localparam logic [DW-1:0] TBL_BASE [NT] = '{32'h1000_0000, 32'h2200_0000, 32'h3330_0000, 32'h4444_0000};
    localparam int            TBL_PASS [NT] = '{3, 3, 3, 3};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid;
    logic [DW-1:0] in_data;
    logic          in_ready;
    logic [RW-1:0] cfg_rows;
    logic          out_ready;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          out_last_row;
    logic          out_last_vec;
    logic          stat_waiting;
    logic          stat_active_sel;

    always #2 clk = ~clk;

    pp_vec_recirc #(.DATA_W(DW), .VEC_LEN(N), .ROW_W(RW)) dut_i (
        .clk             (clk),
        .rst             (rst),
        .in_valid        (in_valid),
        .in_data         (in_data),
        .in_ready        (in_ready),
        .cfg_rows        (cfg_rows),
        .out_ready       (out_ready),
        .out_valid       (out_valid),
        .out_data        (out_data),
        .out_last_row    (out_last_row),
        .out_last_vec    (out_last_vec),
        .stat_waiting    (stat_waiting),
        .stat_active_sel (stat_active_sel)
    );

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] got_d [MAXQ];
    logic          got_lr [MAXQ];
    logic          got_lv [MAXQ];
    int            got_n = 0;
    logic [DW-1:0] exp_d [MAXQ];
    logic          exp_lr [MAXQ];
    logic          exp_lv [MAXQ];
    int            exp_n = 0;
    int            acc_n = 0;
    int            got_at_acc8 = -1;

    always @(negedge clk) begin
        #1;
        if (!rst) begin
            if (in_valid && in_ready) begin
                acc_n++;
                if (acc_n == 2 * N) got_at_acc8 = got_n;
            end
            if (out_valid && out_ready && got_n < MAXQ) begin
                got_d[got_n]  = out_data;
                got_lr[got_n] = out_last_row;
                got_lv[got_n] = out_last_vec;
                got_n++;
            end
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] elem(input logic [DW-1:0] base, input int e);
        return base + (32'(e) + 1) * 32'h0001_0203;
    endfunction

    task automatic push_word(input logic [DW-1:0] d);
        in_valid = 1'b1;
        in_data  = d;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic push_vec(input logic [DW-1:0] base);
        for (int e = 0; e < N; e++) push_word(elem(base, e));
    endtask

    task automatic expect_vec(input logic [DW-1:0] base, input int passes);
        for (int p = 0; p < passes; p++) begin
            for (int e = 0; e < N; e++) begin
                exp_d[exp_n]  = elem(base, e);
                exp_lr[exp_n] = (e == N - 1);
                exp_lv[exp_n] = (p == passes - 1);
                exp_n++;
            end
        end
    endtask

    task automatic wait_valid(input int limit);
        for (int w = 0; w < limit && !out_valid; w++) @(negedge clk);
        #1;
    endtask

    task automatic compare_stream(input string tag);
        for (int w = 0; w < 5000 && got_n < exp_n; w++) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(got_n == exp_n, {tag, " R3 element count"}, 64'(got_n), 64'(exp_n));
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            chk(got_d[i] == exp_d[i], {tag, " R3 data"}, 64'(got_d[i]), 64'(exp_d[i]));
            chk(got_lr[i] == exp_lr[i], {tag, " R4 last_row"}, 64'(got_lr[i]), 64'(exp_lr[i]));
            chk(got_lv[i] == exp_lv[i], {tag, " R5 last_vec"}, 64'(got_lv[i]), 64'(exp_lv[i]));
        end
    endtask

    task automatic do_reset();
        rst       = 1'b1;
        in_valid  = 1'b0;
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R1 out_valid in reset", 64'(out_valid), 64'd0);
        @(negedge clk);
        rst   = 1'b0;
        got_n = 0;
        exp_n = 0;
        acc_n = 0;
        got_at_acc8 = -1;
        @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
        chk(in_ready == 1'b1, "R1 in_ready", 64'(in_ready), 64'd1);
        chk(stat_waiting == 1'b1, "R1 waiting", 64'(stat_waiting), 64'd1);
        chk(stat_active_sel == 1'b0, "R1 select", 64'(stat_active_sel), 64'd0);
    endtask

    initial begin
        logic [DW-1:0] hold;
        in_valid  = 1'b0;
        in_data   = '0;
        out_ready = 1'b1;
        cfg_rows  = RW'(2);

        // Directed: startup load, latch of cfg_rows, waiting, swap, overwrite guard, stall
        do_reset();
        for (int e = 0; e < N - 1; e++) push_word(elem(32'hA000_0000, e));
        repeat (5) @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R2 no output before full vector", 64'(out_valid), 64'd0);
        push_word(elem(32'hA000_0000, N - 1));
        wait_valid(10);
        chk(out_valid == 1'b1, "R2 output after full vector", 64'(out_valid), 64'd1);
        cfg_rows = RW'(5);   // R11: too late for vector A
        expect_vec(32'hA000_0000, 2);
        for (int w = 0; w < 200 && got_n < 2 * N; w++) @(negedge clk);
        repeat (4) @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R8 idle without next vector", 64'(out_valid), 64'd0);
        chk(stat_waiting == 1'b1, "R8 waiting flag", 64'(stat_waiting), 64'd1);
        chk(stat_active_sel == 1'b0, "R8 R9 no swap while loading", 64'(stat_active_sel), 64'd0);

        push_vec(32'hB000_0000);
        wait_valid(10);
        chk(stat_active_sel == 1'b1, "R9 toggle on swap", 64'(stat_active_sel), 64'd1);
        expect_vec(32'hB000_0000, 5);
        cfg_rows = RW'(0);   // R11: zero means one pass for C and D

        fork
            begin
                push_vec(32'hC000_0000);
                #1;
                chk(in_ready == 1'b0, "R7 ready low with loaded vector", 64'(in_ready), 64'd0);
                push_vec(32'hD000_0000);
            end
            begin
                repeat (6) @(negedge clk);
                out_ready = 1'b0;
                #1;
                hold = out_data;
                for (int k = 0; k < 4; k++) begin
                    @(negedge clk);
                    #1;
                    chk(out_valid && out_data == hold, "R10 stall holds element",
                        64'(out_data), 64'(hold));
                end
                out_ready = 1'b1;
            end
        join
        expect_vec(32'hC000_0000, 1);
        expect_vec(32'hD000_0000, 1);
        compare_stream("directed R11");
        chk(stat_active_sel == 1'b1, "R9 select after four activations", 64'(stat_active_sel), 64'd1);

        // Table walk: back-to-back vectors streamed while replay continues
        do_reset();
        cfg_rows = RW'(3);
        for (int t = 0; t < NT; t++) begin
            expect_vec(TBL_BASE[t], TBL_PASS[t]);
            push_vec(TBL_BASE[t]);
        end
        compare_stream("table");
        chk(got_at_acc8 >= 0 && got_at_acc8 < N * TBL_PASS[0],
            "R6 second vector loaded during first replay", 64'(got_at_acc8), 64'(N * TBL_PASS[0]));

        summary();
        $finish;
    end

endmodule